// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a programmed number of bytes from a source region to a destination region through one memory master port. Software-side logic presents a configuration on plain input pins and pulses `start`. The engine then works in bursts. Each burst reads up to one burst length of data from the source into an internal staging buffer, and then writes that data to the destination. The beat widths on the two sides are chosen independently.

Each side has its own address generator. Linear mode steps the address up, steps it down, or holds it. Two-dimensional mode walks a row of a given byte width and then jumps to the next row by a stride. FIFO mode keeps one constant port address. A burst starts either on a rising edge of an external request line, or in free-running mode after a programmed number of idle cycles. A burst that waits too long on the memory port is aborted with an error interrupt. A one-cycle completion interrupt marks the end of a transfer.

The memory port is valid/ready. The engine raises `mem_valid` together with the address, direction, size and write data. A beat completes in any cycle where `mem_ready` is high. Read data on `mem_rdata` is taken in that same cycle. While `mem_ready` is low the engine holds every request field steady, unless the burst timeout aborts it.

Top module: `dma_channel`

## Requirements
- R1: `busy` rises in the cycle after `start` is sampled high while idle, and stays high until completion or error. A `start` pulse while busy has no effect on the ongoing transfer and produces no second transfer.
- R2: The size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. `mem_size` carries the source code on reads and the destination code on writes. Beat data is right-aligned and little-endian: byte i of a beat sits on bits 8i+7:8i.
- R3: Each burst moves min(burst length, bytes remaining). It reads all of its bytes before it writes any of them, so the first burst issues burst/source-size reads before its first write.
- R4: In linear mode (mode 0), direction 0 adds the beat size after every beat, direction 1 subtracts it, and direction 2 holds the address.
- R5: In 2D mode (mode 1), the address advances by the beat size until the row byte width is used up. It then moves to the row start plus the stride, and that address becomes the new row start.
- R6: In FIFO mode (mode 2), every beat on that side uses the start address, whatever the direction.
- R7: With the request mode pin high, no burst begins without a rising edge on `dma_req`. Each rising edge while busy releases exactly one burst.
- R8: In free-running mode with idle gap G, `mem_valid` is low for exactly G+1 cycles between the last write of one burst and the first read of the next.
- R9: With timeout T nonzero, once T stalled cycles (`mem_valid` high, `mem_ready` low) occur within one burst, the engine drops `mem_valid`, clears `busy` and pulses `err_irq` for one cycle.
- R10: The stall count restarts at every burst, so stalls spread across bursts, each burst staying below T, never cause an error.
- R11: After the whole count is moved, `done_irq` is high for exactly one cycle, and `busy` is already low in that cycle.
- R12: While `mem_valid` is high and `mem_ready` low, the next cycle keeps `mem_valid`, `mem_addr`, `mem_write`, `mem_size` and `mem_wdata` unchanged, except on a timeout abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the present configuration |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_count | input | CW | Total bytes to move |
| cfg_src_size | input | 2 | Source beat size code |
| cfg_dst_size | input | 2 | Destination beat size code |
| cfg_burst | input | BW | Burst length in bytes (at most MAX_BURST) |
| cfg_src_mode | input | 2 | Source mode: 0 linear, 1 2D, 2 FIFO |
| cfg_src_dir | input | 2 | Source direction: 0 up, 1 down, 2 hold |
| cfg_dst_mode | input | 2 | Destination mode |
| cfg_dst_dir | input | 2 | Destination direction |
| cfg_src_row | input | RW | Source row width in bytes (2D) |
| cfg_dst_row | input | RW | Destination row width in bytes (2D) |
| cfg_src_stride | input | AW | Source row-to-row stride (2D) |
| cfg_dst_stride | input | AW | Destination row-to-row stride (2D) |
| cfg_req_mode | input | 1 | 1: bursts paced by request edges |
| cfg_idle_gap | input | GW | Idle cycles between bursts when free-running |
| cfg_timeout | input | TW | Stall cycles allowed per burst, 0 disables |
| dma_req | input | 1 | Burst request line |
| mem_valid | output | 1 | Memory beat request valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | 1 write beat, 0 read beat |
| mem_addr | output | AW | Beat byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| err_irq | output | 1 | One-cycle timeout error pulse |

## Verification
The bench sweeps every pairing of the three beat sizes with five side behaviours (up, down, hold, 2D, FIFO). It checks the whole destination image against a byte-by-byte replay of the beats. A wrong decrement sign, a missed row jump or packing on the wrong lane shows up as misplaced bytes. It also covers a partial final burst and a full 64-byte burst: a wrong min() would overrun or drop the tail. Request pacing is checked by counting reads per edge, so a level-sensitive trigger would run on. The gap is measured cycle by cycle, where an off-by-one shows as G or G+2 low cycles. Timeout is checked twice. Under a dead port the exact stall count to abort is measured. Under a port that stalls every other cycle, a counter that never restarts per burst would raise a false error. A second `start` while busy must not redirect or repeat the transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_WRITE
  } dma_state_e;

  // side modes (code 0 and 3 are linear)
  localparam logic [1:0] MODE_2D   = 2'd1;
  localparam logic [1:0] MODE_FIFO = 2'd2;

  // linear directions (any other code holds the address)
  localparam logic [1:0] DIR_INC = 2'd0;
  localparam logic [1:0] DIR_DEC = 2'd1;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [1:0]    mode,
  input  logic [1:0]    dir,
  input  logic [RW-1:0] row_bytes,
  input  logic [AW-1:0] stride,
  input  logic [2:0]    nbytes,
  input  logic          step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, row_base_q, stride_q;
  logic [RW-1:0] row_cnt_q, row_q;
  logic [1:0]    mode_q, dir_q;
  logic [AW-1:0] inc_a;
  logic [RW-1:0] inc_r;

  assign inc_a = {{(AW-3){1'b0}}, nbytes};
  assign inc_r = {{(RW-3){1'b0}}, nbytes};
  assign addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      row_base_q <= '0;
      stride_q   <= '0;
      row_cnt_q  <= '0;
      row_q      <= '0;
      mode_q     <= '0;
      dir_q      <= '0;
    end else if (load) begin
      addr_q     <= base;
      row_base_q <= base;
      stride_q   <= stride;
      row_cnt_q  <= '0;
      row_q      <= row_bytes;
      mode_q     <= mode;
      dir_q      <= dir;
    end else if (step) begin
      case (mode_q)
        MODE_2D: begin
          if (row_cnt_q + inc_r >= row_q) begin
            row_base_q <= row_base_q + stride_q;
            addr_q     <= row_base_q + stride_q;
            row_cnt_q  <= '0;
          end else begin
            addr_q    <= addr_q + inc_a;
            row_cnt_q <= row_cnt_q + inc_r;
          end
        end
        MODE_FIFO: addr_q <= addr_q;
        default: begin
          if (dir_q == DIR_INC)      addr_q <= addr_q + inc_a;
          else if (dir_q == DIR_DEC) addr_q <= addr_q - inc_a;
        end
      endcase
    end
  end

  AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode_q == MODE_FIFO) |=> (addr == $past(addr))); // R6

endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_ptr,
  input  logic [2:0]    wr_n,
  input  logic [31:0]   wr_data,
  input  logic [PW-1:0] rd_ptr,
  output logic [31:0]   rd_data
);

  logic [7:0] bytes_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int j = 0; j < 4; j++) begin
      if (wr_en && (j < int'(wr_n)))
        bytes_q[wr_ptr + PW'(j)] <= wr_data[8*j +: 8];
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign rd_data[8*g +: 8] = bytes_q[rd_ptr + PW'(g)];
  end

endmodule

// File: rtl/dma_tout.sv
module dma_tout #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          stall,
  input  logic [TW-1:0] limit,
  output logic          hit
);

  logic [TW-1:0] cnt_q;

  assign hit = stall && (limit != '0) && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clear || hit)  cnt_q <= '0;
    else if (stall)         cnt_q <= cnt_q + 1'b1;
  end

  AST_TOUT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0 && $stable(limit)) |-> (cnt_q < limit)); // R9

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MAX_BURST = 64,
  parameter int RW = 16,
  parameter int TW = 16,
  parameter int GW = 8,
  localparam int PW = $clog2(MAX_BURST),
  localparam int BW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_src_size,
  input  logic [1:0]    cfg_dst_size,
  input  logic [BW-1:0] cfg_burst,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_src_dir,
  input  logic [1:0]    cfg_dst_mode,
  input  logic [1:0]    cfg_dst_dir,
  input  logic [RW-1:0] cfg_src_row,
  input  logic [RW-1:0] cfg_dst_row,
  input  logic [AW-1:0] cfg_src_stride,
  input  logic [AW-1:0] cfg_dst_stride,
  input  logic          cfg_req_mode,
  input  logic [GW-1:0] cfg_idle_gap,
  input  logic [TW-1:0] cfg_timeout,
  input  logic          dma_req,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done_irq,
  output logic          err_irq
);

  dma_state_e    state_q;
  logic [1:0]    src_sz_q, dst_sz_q;
  logic [BW-1:0] burst_q, blen_q, rd_left_q, wr_left_q, blen_next;
  logic [PW-1:0] fill_ptr_q, drain_ptr_q;
  logic [CW-1:0] remain_q;
  logic          req_mode_q, req_q, pending_q, done_q, err_q;
  logic [GW-1:0] gap_cfg_q, gap_q;
  logic [TW-1:0] tout_q;

  logic [2:0]    src_nb, dst_nb;
  logic [AW-1:0] src_addr, dst_addr;
  logic [31:0]   buf_rd;
  logic          hs, stall, tout_hit, start_ok, begin_burst, finish_now;
  logic          rd_last, wr_last, req_rise, in_rd, in_wr;

  // ---------------- control decode ----------------
  assign src_nb      = size_bytes(src_sz_q);
  assign dst_nb      = size_bytes(dst_sz_q);
  assign in_rd       = (state_q == ST_READ);
  assign in_wr       = (state_q == ST_WRITE);
  assign busy        = (state_q != ST_IDLE);
  assign start_ok    = start && (state_q == ST_IDLE);
  assign hs          = mem_valid && mem_ready;
  assign stall       = mem_valid && !mem_ready;
  assign req_rise    = dma_req && !req_q;
  assign begin_burst = (state_q == ST_WAIT) && (remain_q != '0) &&
                       (req_mode_q ? pending_q : (gap_q == '0));
  assign finish_now  = (state_q == ST_WAIT) && (remain_q == '0);
  assign rd_last     = in_rd && hs && (rd_left_q == {{(BW-3){1'b0}}, src_nb});
  assign wr_last     = in_wr && hs && (wr_left_q == {{(BW-3){1'b0}}, dst_nb});
  assign blen_next   = (remain_q < CW'(burst_q)) ? remain_q[BW-1:0] : burst_q;

  // ---------------- memory port ----------------
  assign mem_valid = in_rd || in_wr;
  assign mem_write = in_wr;
  assign mem_addr  = in_wr ? dst_addr : src_addr;
  assign mem_size  = in_wr ? dst_sz_q : src_sz_q;
  assign mem_wdata = buf_rd;
  assign done_irq  = done_q;
  assign err_irq   = err_q;

  // ---------------- sub-blocks ----------------
  dma_addr_gen #(.AW(AW), .RW(RW)) u_src_ag (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .base(cfg_src_addr),
    .mode(cfg_src_mode), .dir(cfg_src_dir), .row_bytes(cfg_src_row),
    .stride(cfg_src_stride), .nbytes(src_nb), .step(in_rd && hs),
    .addr(src_addr)
  );

  dma_addr_gen #(.AW(AW), .RW(RW)) u_dst_ag (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .base(cfg_dst_addr),
    .mode(cfg_dst_mode), .dir(cfg_dst_dir), .row_bytes(cfg_dst_row),
    .stride(cfg_dst_stride), .nbytes(dst_nb), .step(in_wr && hs),
    .addr(dst_addr)
  );

  dma_burst_buf #(.DEPTH(MAX_BURST)) u_buf (
    .clk(clk), .wr_en(in_rd && hs), .wr_ptr(fill_ptr_q), .wr_n(src_nb),
    .wr_data(mem_rdata), .rd_ptr(drain_ptr_q), .rd_data(buf_rd)
  );

  dma_tout #(.TW(TW)) u_tout (
    .clk(clk), .rst_n(rst_n), .clear(begin_burst || start_ok),
    .stall(stall), .limit(tout_q), .hit(tout_hit)
  );

  // ---------------- request edge capture ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      req_q <= dma_req;
      if (start_ok)               pending_q <= 1'b0;
      else if (req_rise && busy)  pending_q <= 1'b1;
      else if (begin_burst)       pending_q <= 1'b0;
    end
  end

  // ---------------- main sequencer ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      src_sz_q    <= '0;
      dst_sz_q    <= '0;
      burst_q     <= '0;
      blen_q      <= '0;
      rd_left_q   <= '0;
      wr_left_q   <= '0;
      fill_ptr_q  <= '0;
      drain_ptr_q <= '0;
      remain_q    <= '0;
      req_mode_q  <= 1'b0;
      gap_cfg_q   <= '0;
      gap_q       <= '0;
      tout_q      <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            src_sz_q   <= cfg_src_size;
            dst_sz_q   <= cfg_dst_size;
            burst_q    <= cfg_burst;
            remain_q   <= cfg_count;
            req_mode_q <= cfg_req_mode;
            gap_cfg_q  <= cfg_idle_gap;
            tout_q     <= cfg_timeout;
            gap_q      <= '0;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (finish_now) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (begin_burst) begin
            blen_q      <= blen_next;
            rd_left_q   <= blen_next;
            wr_left_q   <= blen_next;
            fill_ptr_q  <= '0;
            drain_ptr_q <= '0;
            state_q     <= ST_READ;
          end else if (!req_mode_q && gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
          end
        end
        ST_READ: begin
          if (tout_hit) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (hs) begin
            fill_ptr_q <= fill_ptr_q + {{(PW-3){1'b0}}, src_nb};
            rd_left_q  <= rd_left_q - {{(BW-3){1'b0}}, src_nb};
            if (rd_last) state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (tout_hit) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (hs) begin
            drain_ptr_q <= drain_ptr_q + {{(PW-3){1'b0}}, dst_nb};
            wr_left_q   <= wr_left_q - {{(BW-3){1'b0}}, dst_nb};
            if (wr_last) begin
              remain_q <= remain_q - CW'(blen_q);
              if (remain_q == CW'(blen_q)) begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                gap_q   <= gap_cfg_q;
                state_q <= ST_WAIT;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !tout_hit) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) &&
       $stable(mem_size) && $stable(mem_wdata))); // R12

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ($past(stall) && !busy)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R11

endmodule

// File: tb/sim_dma_channel.sv
`timescale 1ns/1ps
module sim_dma_channel;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, dma_req;
  logic [31:0] cfg_src_addr, cfg_dst_addr, cfg_src_stride, cfg_dst_stride;
  logic [15:0] cfg_count, cfg_src_row, cfg_dst_row, cfg_timeout;
  logic [1:0]  cfg_src_size, cfg_dst_size, cfg_src_mode, cfg_src_dir, cfg_dst_mode, cfg_dst_dir;
  logic [6:0]  cfg_burst;
  logic        cfg_req_mode;
  logic [7:0]  cfg_idle_gap;
  logic        mem_valid, mem_ready, mem_write, busy, done_irq, err_irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  dma_channel u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_count(cfg_count),
    .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size), .cfg_burst(cfg_burst),
    .cfg_src_mode(cfg_src_mode), .cfg_src_dir(cfg_src_dir),
    .cfg_dst_mode(cfg_dst_mode), .cfg_dst_dir(cfg_dst_dir),
    .cfg_src_row(cfg_src_row), .cfg_dst_row(cfg_dst_row),
    .cfg_src_stride(cfg_src_stride), .cfg_dst_stride(cfg_dst_stride),
    .cfg_req_mode(cfg_req_mode), .cfg_idle_gap(cfg_idle_gap), .cfg_timeout(cfg_timeout),
    .dma_req(dma_req), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done_irq(done_irq), .err_irq(err_irq)
  );

  // ---------------- memory model ----------------
  logic [7:0] mem [0:1023];
  logic [7:0] exp_mem [0:1023];
  logic       init_req = 1'b0;
  logic [1:0] rdy_mode = 2'd0;
  logic       tog = 1'b0;
  logic [9:0] ra;

  function automatic logic [7:0] iv(input int i);
    return (i < 512) ? 8'(i * 7 + 3) : 8'hEE;
  endfunction

  function automatic int nb(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  assign ra        = mem_addr[9:0];
  assign mem_rdata = {mem[ra + 10'd3], mem[ra + 10'd2], mem[ra + 10'd1], mem[ra]};
  assign mem_ready = (rdy_mode == 2'd0) ? 1'b1 : (rdy_mode == 2'd1) ? 1'b0 : tog;

  always @(posedge clk) begin
    tog <= ~tog;
    if (init_req) begin
      for (int i = 0; i < 1024; i++) mem[i] <= iv(i);
    end else if (mem_valid && mem_ready && mem_write) begin
      for (int j = 0; j < 4; j++)
        if (j < nb(int'(mem_size))) mem[(int'(ra) + j) & 1023] <= mem_wdata[8*j +: 8];
    end
  end

  // ---------------- monitors ----------------
  int size_bad = 0, hold_bad = 0;
  logic        hold_prev = 1'b0;
  logic [31:0] h_addr, h_data;
  logic        h_wr;
  always @(negedge clk) begin
    if (mem_valid && mem_size != (mem_write ? cfg_dst_size : cfg_src_size)) size_bad++;
    if (hold_prev && !err_irq &&
        (!mem_valid || mem_addr !== h_addr || mem_wdata !== h_data || mem_write !== h_wr))
      hold_bad++;
    hold_prev = mem_valid && !mem_ready;
    h_addr = mem_addr; h_data = mem_wdata; h_wr = mem_write;
  end

  // ---------------- bookkeeping ----------------
  int vec = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  task automatic init_mem();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  // kind: 0 up, 1 down, 2 hold, 3 2D, 4 FIFO
  task automatic set_side(input bit is_src, input int kind);
    logic [1:0] m, d;
    int base;
    case (kind)
      0: begin m = 0; d = 0; base = 64;  end
      1: begin m = 0; d = 1; base = 400; end
      2: begin m = 0; d = 2; base = 100; end
      3: begin m = 1; d = 0; base = 128; end
      default: begin m = 2; d = 1; base = 300; end
    endcase
    if (is_src) begin
      cfg_src_mode = m; cfg_src_dir = d; cfg_src_addr = base;
      cfg_src_row = 16'd8; cfg_src_stride = 32'd16;
    end else begin
      cfg_dst_mode = m; cfg_dst_dir = d; cfg_dst_addr = base + 512;
      cfg_dst_row = 16'd8; cfg_dst_stride = 32'd16;
    end
  endtask

  function automatic int baddr(input int base, input int m, input int d, input int n,
                               input int k, input int row, input int stride);
    int epr;
    if (m == 2) return base;
    if (m == 1) begin
      epr = row / n;
      return base + (k / epr) * stride + (k % epr) * n;
    end
    if (d == 0) return base + k * n;
    if (d == 1) return base - k * n;
    return base;
  endfunction

  task automatic build_exp();
    int sn, dn, sa, da;
    sn = nb(int'(cfg_src_size));
    dn = nb(int'(cfg_dst_size));
    for (int i = 0; i < 1024; i++) exp_mem[i] = iv(i);
    for (int b = 0; b < int'(cfg_count); b++) begin
      sa = baddr(int'(cfg_src_addr), int'(cfg_src_mode), int'(cfg_src_dir), sn, b / sn,
                 int'(cfg_src_row), int'(cfg_src_stride)) + b % sn;
      da = baddr(int'(cfg_dst_addr), int'(cfg_dst_mode), int'(cfg_dst_dir), dn, b / dn,
                 int'(cfg_dst_row), int'(cfg_dst_stride)) + b % dn;
      exp_mem[da & 1023] = iv(sa & 1023);
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = -1;
    for (int i = 512; i < 1024; i++)
      if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " byte mismatch"}, int'(mem[bad]), int'(exp_mem[bad]));
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // waits for an interrupt; returns mem_valid cycles seen, and checks the pulse
  task automatic wait_end(output int vcyc, output bit got_done, output bit got_err);
    bit busy_at;
    vcyc = 0; got_done = 0; got_err = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done_irq || err_irq) break;
      if (mem_valid) vcyc++;
      @(negedge clk);
    end
    got_done = done_irq; got_err = err_irq; busy_at = busy;
    if (got_done) chk(!busy_at, "R11 busy low with done", int'(busy_at), 0);
    @(negedge clk);
    if (got_done) chk(!done_irq, "R11 done one cycle", int'(done_irq), 0);
  endtask

  task automatic base_cfg();
    cfg_src_size = 2; cfg_dst_size = 2; cfg_count = 48; cfg_burst = 16;
    cfg_req_mode = 0; cfg_idle_gap = 0; cfg_timeout = 0; dma_req = 0;
    set_side(1, 0); set_side(0, 0);
  endtask

  initial begin
    int vc, runs, run_len, reads, stalls;
    bit gd, ge, seen, in_gap;
    rst_n = 0; start = 0;
    base_cfg();
    init_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_valid && !done_irq && !err_irq, "R1 reset outputs quiet",
        int'({busy, mem_valid, done_irq, err_irq}), 0);
    rst_n = 1;
    @(negedge clk);

    // ---- sweep: sizes x side kinds (R2 R4 R5 R6) ----
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int sk = 0; sk < 5; sk++)
          for (int dk = 0; dk < 5; dk++) begin
            base_cfg();
            cfg_src_size = 2'(ss); cfg_dst_size = 2'(ds);
            set_side(1, sk); set_side(0, dk);
            init_mem(); build_exp();
            size_bad = 0;
            pulse_start();
            wait_end(vc, gd, ge);
            chk(gd && !ge, "R11 sweep completes", int'(gd), 1);
            chk(size_bad == 0, "R2 mem_size per side", size_bad, 0);
            cmp_mem((sk == 3 || dk == 3) ? "R5 2D image" :
                    (sk == 4 || dk == 4) ? "R6 FIFO image" : "R4 linear image");
          end

    // ---- R3 partial last burst, read-before-write ----
    base_cfg(); cfg_count = 40; cfg_burst = 24; cfg_src_size = 1; cfg_dst_size = 2;
    init_mem(); build_exp();
    pulse_start();
    reads = 0; seen = 0;
    for (int i = 0; i < 200 && !done_irq; i++) begin
      if (mem_valid && mem_ready && mem_write) seen = 1;
      if (mem_valid && mem_ready && !mem_write && !seen) reads++;
      @(negedge clk);
    end
    chk(reads == 12, "R3 reads before first write", reads, 12);
    @(negedge clk);
    cmp_mem("R3 partial burst image");

    // ---- R3 full 64-byte burst ----
    base_cfg(); cfg_count = 64; cfg_burst = 64; cfg_src_size = 0; cfg_dst_size = 2;
    set_side(0, 1);
    init_mem(); build_exp();
    pulse_start(); wait_end(vc, gd, ge);
    chk(gd, "R3 full burst done", int'(gd), 1);
    cmp_mem("R3 full burst image");

    // ---- R7 request pacing ----
    base_cfg(); cfg_req_mode = 1;
    init_mem(); build_exp();
    pulse_start();
    vc = 0;
    for (int i = 0; i < 20; i++) begin if (mem_valid) vc++; @(negedge clk); end
    chk(vc == 0, "R7 no burst without request edge", vc, 0);
    seen = 0;
    for (int b = 0; b < 3; b++) begin
      dma_req = 1; @(negedge clk); dma_req = 0;
      reads = 0;
      for (int i = 0; i < 25; i++) begin
        if (mem_valid && mem_ready && !mem_write) reads++;
        if (done_irq) seen = 1;
        @(negedge clk);
      end
      chk(reads == 4, "R7 one burst per edge", reads, 4);
    end
    chk(seen && !busy, "R7 paced transfer completes", int'(seen), 1);
    cmp_mem("R7 paced image");

    // ---- R8 idle gap ----
    base_cfg(); cfg_idle_gap = 3;
    init_mem(); build_exp();
    pulse_start();
    runs = 0; run_len = 0; seen = 0; in_gap = 0;
    for (int i = 0; i < 300 && !done_irq; i++) begin
      if (mem_valid) begin
        if (in_gap) begin
          runs++;
          chk(run_len == 4, "R8 gap length G+1", run_len, 4);
        end
        seen = 1; in_gap = 0; run_len = 0;
      end else if (seen) begin
        in_gap = 1; run_len++;
      end
      @(negedge clk);
    end
    chk(runs == 2, "R8 gaps between three bursts", runs, 2);

    // ---- R9 timeout on dead port ----
    @(negedge clk);
    base_cfg(); cfg_count = 16; cfg_timeout = 5; rdy_mode = 1;
    pulse_start(); wait_end(vc, gd, ge);
    chk(ge && !gd, "R9 error raised", int'(ge), 1);
    chk(vc == 5, "R9 stall cycles before abort", vc, 5);
    chk(!busy && !mem_valid, "R9 engine idle after abort", int'({busy, mem_valid}), 0);
    rdy_mode = 0;

    // ---- R10 / R12 per-burst restart under toggling ready ----
    base_cfg(); cfg_timeout = 10; rdy_mode = 2;
    init_mem(); build_exp();
    hold_bad = 0;
    pulse_start();
    stalls = 0; ge = 0; gd = 0;
    for (int i = 0; i < 400; i++) begin
      if (mem_valid && !mem_ready) stalls++;
      if (err_irq) ge = 1;
      if (done_irq) begin gd = 1; break; end
      @(negedge clk);
    end
    chk(gd && !ge, "R10 no error across bursts", int'(ge), 0);
    chk(stalls > 10, "R10 total stalls exceed limit", stalls, 11);
    chk(hold_bad == 0, "R12 request held while stalled", hold_bad, 0);
    rdy_mode = 0;
    @(negedge clk);
    cmp_mem("R10 image under stalls");

    // ---- R1 start ignored while busy ----
    base_cfg();
    init_mem(); build_exp();
    pulse_start();
    chk(busy, "R1 busy after start", int'(busy), 1);
    repeat (3) @(negedge clk);
    cfg_dst_addr = 612; cfg_count = 8;
    start = 1; @(negedge clk); start = 0;
    wait_end(vc, gd, ge);
    chk(gd, "R1 first transfer completes", int'(gd), 1);
    vc = 0;
    for (int i = 0; i < 60; i++) begin
      if (mem_valid || done_irq || busy) vc++;
      @(negedge clk);
    end
    chk(vc == 0, "R1 no second transfer", vc, 0);
    cmp_mem("R1 image unchanged by late start");

    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

endmodule